// File: doc/BRIEF.md
# Block-Level SECDED Error Corrector

This block guards a long stream of samples that is parked in bulk memory. On the way in, it builds one check word over each group of `BLK_LEN` samples and hands that word out for separate check storage. On the way out, it takes the samples back together with their stored check word. It holds the whole group in a two-bank buffer and resolves the syndrome. Only then does it release the group, in order, with any single flipped bit repaired. Two flipped bits are flagged as uncorrectable and the data passes unchanged.

The code is an extended Hamming code. Data bit `d` (sample index times `SMP_W` plus bit index) sits at codeword position `P(d) = 2^K + 1 + d`, where `K = clog2(BLK_LEN*SMP_W + 1)`. Check bit `j` sits at position `2^j` for `j = 0..K`. The syndrome is the XOR of the positions of all set bits, and one overall parity bit makes the whole codeword even. Host-visible saturating counters record repaired and uncorrectable groups, along with the block address and syndrome of the most recent event of each kind. A repeatedly failing memory lane therefore shows up as the same position recurring.

Top module: `blk_secded`

## Requirements
- R1: One cycle after the write port accepts the last sample of a group, `wr_code_valid` pulses for a single cycle. `wr_code[K:0]` holds the XOR of `P(d)` over all set data bits, `wr_code[K+1]` makes the parity of all data bits and `wr_code[K+1:0]` even, and the bits above K+1 are zero.
- R2: A group read back with its matching code is released unchanged with `out_status` = 2'b00.
- R3: A group with exactly one flipped data bit is released with that bit restored and `out_status` = 2'b01.
- R4: A single flipped check bit or overall parity bit leaves the released data equal to the received data, gives `out_status` = 2'b01, and counts as a corrected event.
- R5: Two flipped bits anywhere in the codeword, or an odd-parity syndrome that names no valid position, release the received data unaltered with `out_status` = 2'b10.
- R6: No sample of a group leaves before the whole group has arrived. The first released sample is registered on the second rising edge after the edge that accepts the group's last sample.
- R7: Each group leaves as `BLK_LEN` samples on consecutive cycles in arrival order. `out_first` marks the first sample and `out_last` marks the last.
- R8: `sec_count` and `ded_count` reset to zero, rise by one per corrected or uncorrectable group, and hold at all ones.
- R9: Each counted event stores the block address and the syndrome. The block address is sampled with the group's first sample, together with `rd_code`. The syndrome is `P(d)` for a data bit, `2^j` for check bit j, 0 for the parity bit, and the XOR of the two positions for a double error. These go to `*_last_addr` and `*_last_pos`.
- R10: Groups may arrive back to back with no idle cycle, and each is classified and repaired independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write-side sample strobe |
| wr_data | input | SMP_W | Write-side sample |
| wr_code_valid | output | 1 | Check word strobe |
| wr_code | output | CODE_W | Check word for the group just written |
| rd_valid | input | 1 | Read-side sample strobe |
| rd_data | input | SMP_W | Sample returned from bulk memory |
| rd_code | input | CODE_W | Stored check word, taken with the first sample |
| rd_addr | input | ADDR_W | Block address, taken with the first sample |
| out_valid | output | 1 | Released sample strobe |
| out_data | output | SMP_W | Released, repaired sample |
| out_first | output | 1 | First sample of a group |
| out_last | output | 1 | Last sample of a group |
| out_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| sec_count | output | CNT_W | Corrected-group counter |
| sec_last_addr | output | ADDR_W | Block address of last corrected event |
| sec_last_pos | output | CODE_W | Syndrome of last corrected event |
| ded_count | output | CNT_W | Uncorrectable-group counter |
| ded_last_addr | output | ADDR_W | Block address of last uncorrectable event |
| ded_last_pos | output | CODE_W | Syndrome of last uncorrectable event |

## Verification
The encoder is driven with all-zero, all-one and mixed groups, and with a walking single one through every data bit. The walking one separates the position of each bit in the syndrome. The read side sweeps a single flip through every data bit, then each check bit and the parity bit, so the data repair path and the check-only path are told apart. It also tries adjacent data-bit pairs and mixed pairs that must be flagged rather than repaired. The sweeps run long enough to drive both counters into saturation. A final pair of back-to-back groups, one damaged and one clean, shows that repair state does not leak from one group into the next.

// File: rtl/secded_pkg.sv
package secded_pkg;
  typedef enum logic [1:0] {
    BLK_CLEAN = 2'b00,
    BLK_FIXED = 2'b01,
    BLK_FATAL = 2'b10
  } blk_status_e;
endpackage

// File: rtl/ecc_fold.sv
// Folds one sample into a partial syndrome: XOR of codeword positions of set bits.
module ecc_fold #(
  parameter int W     = 16,
  parameter int IDX_W = 7,
  parameter int SYN_W = 13
) (
  input  logic [W-1:0]     smp,
  input  logic [IDX_W-1:0] idx,
  output logic [SYN_W-1:0] fold,
  output logic             par
);
  localparam logic [SYN_W-1:0] TOP = SYN_W'(1) << (SYN_W - 1);

  always_comb begin
    fold = '0;
    par  = ^smp;
    for (int b = 0; b < W; b++) begin
      if (smp[b]) fold ^= TOP + SYN_W'(1) + SYN_W'(idx) * SYN_W'(W) + SYN_W'(b);
    end
  end
endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter int N      = 128,
  parameter int W      = 16,
  parameter int CODE_W = 16,
  parameter int SYN_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      in_data,
  output logic              code_valid,
  output logic [CODE_W-1:0] code
);
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] idx;
  logic [SYN_W-1:0] acc, acc_nx, f_syn;
  logic             pacc, pacc_nx, f_par;

  ecc_fold #(.W(W), .IDX_W(IDX_W), .SYN_W(SYN_W)) u_fold (
    .smp(in_data), .idx(idx), .fold(f_syn), .par(f_par)
  );

  assign acc_nx  = (idx == '0) ? f_syn : (acc ^ f_syn);
  assign pacc_nx = (idx == '0) ? f_par : (pacc ^ f_par);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      acc        <= '0;
      pacc       <= 1'b0;
      code_valid <= 1'b0;
      code       <= '0;
    end else begin
      code_valid <= in_valid && (idx == LAST);
      if (in_valid) begin
        idx  <= (idx == LAST) ? '0 : idx + 1'b1;
        acc  <= acc_nx;
        pacc <= pacc_nx;
        if (idx == LAST) code <= CODE_W'({pacc_nx ^ (^acc_nx), acc_nx});
      end
    end
  end

  // R1: the check word is a single-cycle pulse per group
  p_code_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> !code_valid);
endmodule

// File: rtl/ecc_bank_ram.sv
// Simple dual-port buffer with registered read, suitable for block RAM.
module ecc_bank_ram #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [0:(1<<AW)-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker
  import secded_pkg::*;
#(
  parameter int N      = 128,
  parameter int W      = 16,
  parameter int ADDR_W = 24,
  parameter int SYN_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_valid,
  input  logic [W-1:0]            rd_data,
  input  logic [SYN_W:0]          rd_code,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    ram_we,
  output logic [$clog2(N):0]      ram_waddr,
  output logic [W-1:0]            ram_wdata,
  output logic [$clog2(N):0]      ram_raddr,
  input  logic [W-1:0]            ram_rdata,
  output logic                    out_valid,
  output logic [W-1:0]            out_data,
  output logic                    out_first,
  output logic                    out_last,
  output logic [1:0]              out_status,
  output logic                    evt_sec,
  output logic                    evt_ded,
  output logic [ADDR_W-1:0]       evt_addr,
  output logic [SYN_W-1:0]        evt_pos
);
  localparam int IDX_W = $clog2(N);
  localparam int BIT_W = $clog2(W);
  localparam int NBITS = N * W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
  localparam logic [SYN_W-1:0] TOP  = SYN_W'(1) << (SYN_W - 1);

  // ---------------- intake: buffer and accumulate ----------------
  logic [IDX_W-1:0]  in_idx;
  logic              in_bank;
  logic [SYN_W-1:0]  acc, acc_nx, f_syn, code_syn;
  logic              pacc, pacc_nx, f_par, code_par;
  logic [ADDR_W-1:0] addr_q;
  logic              blk_end;

  ecc_fold #(.W(W), .IDX_W(IDX_W), .SYN_W(SYN_W)) u_fold (
    .smp(rd_data), .idx(in_idx), .fold(f_syn), .par(f_par)
  );

  assign acc_nx    = (in_idx == '0) ? f_syn : (acc ^ f_syn);
  assign pacc_nx   = (in_idx == '0) ? f_par : (pacc ^ f_par);
  assign blk_end   = rd_valid && (in_idx == LAST);
  assign ram_we    = rd_valid;
  assign ram_waddr = {in_bank, in_idx};
  assign ram_wdata = rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_idx   <= '0;
      in_bank  <= 1'b0;
      acc      <= '0;
      pacc     <= 1'b0;
      code_syn <= '0;
      code_par <= 1'b0;
      addr_q   <= '0;
    end else if (rd_valid) begin
      in_idx <= (in_idx == LAST) ? '0 : in_idx + 1'b1;
      if (in_idx == LAST) in_bank <= ~in_bank;
      acc  <= acc_nx;
      pacc <= pacc_nx;
      if (in_idx == '0) begin
        code_syn <= rd_code[SYN_W-1:0];
        code_par <= rd_code[SYN_W];
        addr_q   <= rd_addr;
      end
    end
  end

  // ---------------- classification of the finished group ----------------
  logic [SYN_W-1:0] syn, dpos;
  logic             odd, pow2, hit, cls_flip;
  logic [IDX_W-1:0] cls_fsmp;
  logic [BIT_W-1:0] cls_fbit;
  blk_status_e      cls_st;

  always_comb begin
    syn      = acc_nx ^ code_syn;
    odd      = pacc_nx ^ code_par ^ (^code_syn);
    pow2     = (syn != '0) && ((syn & (syn - SYN_W'(1))) == '0);
    hit      = (syn >= TOP + SYN_W'(1)) && (syn <= TOP + SYN_W'(NBITS));
    dpos     = syn - TOP - SYN_W'(1);
    cls_fsmp = IDX_W'(dpos / SYN_W'(W));
    cls_fbit = BIT_W'(dpos % SYN_W'(W));
    cls_flip = odd && hit;
    if (!odd)                         cls_st = (syn == '0) ? BLK_CLEAN : BLK_FATAL;
    else if (syn == '0 || pow2 || hit) cls_st = BLK_FIXED;
    else                              cls_st = BLK_FATAL;
  end

  // ---------------- release engine ----------------
  logic             rel_active, rel_bank, cur_flip;
  logic [IDX_W-1:0] rel_idx, cur_fsmp;
  logic [BIT_W-1:0] cur_fbit;
  blk_status_e      cur_st;

  logic             s1_valid, s1_flip;
  logic [IDX_W-1:0] s1_idx;
  logic [BIT_W-1:0] s1_fbit;
  blk_status_e      s1_st;

  assign ram_raddr = {rel_bank, rel_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_active <= 1'b0;
      rel_idx    <= '0;
      rel_bank   <= 1'b0;
      cur_flip   <= 1'b0;
      cur_fsmp   <= '0;
      cur_fbit   <= '0;
      cur_st     <= BLK_CLEAN;
      evt_sec    <= 1'b0;
      evt_ded    <= 1'b0;
      evt_addr   <= '0;
      evt_pos    <= '0;
    end else begin
      evt_sec  <= blk_end && (cls_st == BLK_FIXED);
      evt_ded  <= blk_end && (cls_st == BLK_FATAL);
      evt_addr <= addr_q;
      evt_pos  <= syn;
      if (blk_end) begin
        rel_active <= 1'b1;
        rel_idx    <= '0;
        rel_bank   <= in_bank;
        cur_flip   <= cls_flip;
        cur_fsmp   <= cls_fsmp;
        cur_fbit   <= cls_fbit;
        cur_st     <= cls_st;
      end else if (rel_active) begin
        rel_idx <= rel_idx + 1'b1;
        if (rel_idx == LAST) rel_active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_flip    <= 1'b0;
      s1_idx     <= '0;
      s1_fbit    <= '0;
      s1_st      <= BLK_CLEAN;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      out_status <= BLK_CLEAN;
    end else begin
      s1_valid   <= rel_active;
      s1_flip    <= rel_active && cur_flip && (rel_idx == cur_fsmp);
      s1_idx     <= rel_idx;
      s1_fbit    <= cur_fbit;
      s1_st      <= cur_st;
      out_valid  <= s1_valid;
      out_data   <= ram_rdata ^ (s1_flip ? (W'(1) << s1_fbit) : W'(0));
      out_first  <= s1_valid && (s1_idx == '0);
      out_last   <= s1_valid && (s1_idx == LAST);
      out_status <= s1_valid ? s1_st : BLK_CLEAN;
    end
  end

  // R6: a release only begins on the cycle after a group completes
  p_release_follows_block_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rel_active) |-> $past(blk_end));
  // R7: a group streams out without gaps and without a second start marker
  p_stream_contiguous_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_valid && !out_first));
  // R5: status is never both corrected and uncorrectable
  p_status_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(out_status));
  // R9: at most one event kind per group
  p_single_event_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({evt_sec, evt_ded}) <= 1);
endmodule

// File: rtl/blk_secded.sv
module blk_secded #(
  parameter int BLK_LEN = 128,
  parameter int SMP_W   = 16,
  parameter int CODE_W  = 16,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [SMP_W-1:0]  wr_data,
  output logic              wr_code_valid,
  output logic [CODE_W-1:0] wr_code,
  input  logic              rd_valid,
  input  logic [SMP_W-1:0]  rd_data,
  input  logic [CODE_W-1:0] rd_code,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [SMP_W-1:0]  out_data,
  output logic              out_first,
  output logic              out_last,
  output logic [1:0]        out_status,
  output logic [CNT_W-1:0]  sec_count,
  output logic [ADDR_W-1:0] sec_last_addr,
  output logic [CODE_W-1:0] sec_last_pos,
  output logic [CNT_W-1:0]  ded_count,
  output logic [ADDR_W-1:0] ded_last_addr,
  output logic [CODE_W-1:0] ded_last_pos
);
  localparam int SYN_W = $clog2(BLK_LEN * SMP_W + 1) + 1;
  localparam int RAW   = $clog2(BLK_LEN) + 1;

  generate
    if (CODE_W > SYN_W + 1) begin : g_hi
      logic code_hi_unused;
      assign code_hi_unused = ^rd_code[CODE_W-1:SYN_W+1];
    end
  endgenerate

  ecc_encoder #(.N(BLK_LEN), .W(SMP_W), .CODE_W(CODE_W), .SYN_W(SYN_W)) u_enc (
    .clk(clk), .rst(rst), .in_valid(wr_valid), .in_data(wr_data),
    .code_valid(wr_code_valid), .code(wr_code)
  );

  logic             ram_we;
  logic [RAW-1:0]   ram_waddr, ram_raddr;
  logic [SMP_W-1:0] ram_wdata, ram_rdata;

  ecc_bank_ram #(.W(SMP_W), .AW(RAW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  logic              evt_sec, evt_ded;
  logic [ADDR_W-1:0] evt_addr;
  logic [SYN_W-1:0]  evt_pos;

  ecc_checker #(.N(BLK_LEN), .W(SMP_W), .ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_chk (
    .clk(clk), .rst(rst),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_code(rd_code[SYN_W:0]), .rd_addr(rd_addr),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .out_status(out_status),
    .evt_sec(evt_sec), .evt_ded(evt_ded), .evt_addr(evt_addr), .evt_pos(evt_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_count     <= '0;
      sec_last_addr <= '0;
      sec_last_pos  <= '0;
      ded_count     <= '0;
      ded_last_addr <= '0;
      ded_last_pos  <= '0;
    end else begin
      if (evt_sec) begin
        if (sec_count != '1) sec_count <= sec_count + 1'b1;
        sec_last_addr <= evt_addr;
        sec_last_pos  <= CODE_W'(evt_pos);
      end
      if (evt_ded) begin
        if (ded_count != '1) ded_count <= ded_count + 1'b1;
        ded_last_addr <= evt_addr;
        ded_last_pos  <= CODE_W'(evt_pos);
      end
    end
  end

  // R8: counters move only by single steps and never wrap
  p_sec_step_r8: assert property (@(posedge clk) disable iff (rst)
    (sec_count != $past(sec_count)) |-> (sec_count == CNT_W'($past(sec_count) + 1'b1)));
  p_ded_step_r8: assert property (@(posedge clk) disable iff (rst)
    (ded_count != $past(ded_count)) |-> (ded_count == CNT_W'($past(ded_count) + 1'b1)));
  p_sec_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(sec_count) == '1) |-> (sec_count == '1));
endmodule

// File: tb/blk_secded_bench.sv
`timescale 1ns/1ps
module blk_secded_bench;
  localparam int N = 4, W = 8, CW = 16, CNT = 4, AW = 4, NB = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [W-1:0] wr_data = '0, rd_data = '0;
  logic [CW-1:0] rd_code = '0;
  logic [AW-1:0] rd_addr = '0;
  logic wr_code_valid, out_valid, out_first, out_last;
  logic [CW-1:0] wr_code, sec_last_pos, ded_last_pos;
  logic [W-1:0] out_data;
  logic [1:0] out_status;
  logic [CNT-1:0] sec_count, ded_count;
  logic [AW-1:0] sec_last_addr, ded_last_addr;

  blk_secded #(.BLK_LEN(N), .SMP_W(W), .CODE_W(CW), .CNT_W(CNT), .ADDR_W(AW)) u_blk_secded (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_code_valid(wr_code_valid), .wr_code(wr_code),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_code(rd_code), .rd_addr(rd_addr),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .out_status(out_status),
    .sec_count(sec_count), .sec_last_addr(sec_last_addr), .sec_last_pos(sec_last_pos),
    .ded_count(ded_count), .ded_last_addr(ded_last_addr), .ded_last_pos(ded_last_pos)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  int sec_m = 0, ded_m = 0;
  logic [AW-1:0] sec_a_m = '0, ded_a_m = '0;
  logic [CW-1:0] sec_p_m = '0, ded_p_m = '0;

  logic [W-1:0] cap_d [8];
  logic [1:0]   cap_s [8];
  logic         cap_f [8];
  logic         cap_l [8];
  int cap_n = 0, first_cyc = 0, last_in = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      if (cap_n < 8) begin
        cap_d[cap_n] = out_data;
        cap_s[cap_n] = out_status;
        cap_f[cap_n] = out_first;
        cap_l[cap_n] = out_last;
      end
      if (cap_n == 0) first_cyc = cyc;
      cap_n++;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Codeword per R1: data bit d at position 2^K+1+d, K=6 for 32 data bits.
  function automatic logic [15:0] mk_code(input logic [31:0] v);
    logic [6:0] s = '0;
    logic p;
    for (int d = 0; d < NB; d++) if (v[d]) s ^= 7'(64 + 1 + d);
    p = (^v) ^ (^s);
    return {8'h00, p, s};
  endfunction

  task automatic wr_case(input logic [31:0] v);
    for (int s = 0; s < N; s++) begin
      wr_valid = 1'b1;
      wr_data  = v[s*W +: W];
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk("R1", "code strobe", 64'(wr_code_valid), 64'd1);
    chk("R1", "code word", 64'(wr_code), 64'(mk_code(v)));
    @(negedge clk);
    chk("R1", "strobe single cycle", 64'(wr_code_valid), 64'd0);
  endtask

  task automatic send(input logic [31:0] v, input logic [15:0] c, input logic [AW-1:0] a);
    for (int s = 0; s < N; s++) begin
      rd_valid = 1'b1;
      rd_data  = v[s*W +: W];
      rd_code  = c;
      rd_addr  = a;
      @(negedge clk);
    end
    rd_valid = 1'b0;
    last_in  = cyc;
  endtask

  task automatic model(input logic [1:0] st, input logic [AW-1:0] a, input logic [CW-1:0] pos);
    if (st == 2'b01) begin
      if (sec_m < 15) sec_m++;
      sec_a_m = a; sec_p_m = pos;
    end else if (st == 2'b10) begin
      if (ded_m < 15) ded_m++;
      ded_a_m = a; ded_p_m = pos;
    end
  endtask

  task automatic chk_logs(input string req);
    chk("R8", "sec count", 64'(sec_count), 64'(sec_m));
    chk("R8", "ded count", 64'(ded_count), 64'(ded_m));
    chk(req, "sec addr R9", 64'(sec_last_addr), 64'(sec_a_m));
    chk(req, "sec pos R9", 64'(sec_last_pos), 64'(sec_p_m));
    chk(req, "ded addr R9", 64'(ded_last_addr), 64'(ded_a_m));
    chk(req, "ded pos R9", 64'(ded_last_pos), 64'(ded_p_m));
  endtask

  task automatic rd_case(input string req, input logic [31:0] good, input logic [31:0] fd,
                         input logic [7:0] fc, input logic [AW-1:0] a,
                         input logic [1:0] est, input logic [31:0] eout, input logic [CW-1:0] epos);
    cap_n = 0;
    send(good ^ fd, mk_code(good) ^ {8'h00, fc}, a);
    repeat (8) @(negedge clk);
    chk(req, "sample count R7", 64'(cap_n), 64'(N));
    chk("R6", "release latency", 64'(first_cyc - last_in), 64'd2);
    for (int s = 0; s < N; s++) begin
      chk(req, "data", 64'(cap_d[s]), 64'(eout[s*W +: W]));
      chk(req, "status", 64'(cap_s[s]), 64'(est));
      chk("R7", "first flag", 64'(cap_f[s]), 64'(s == 0));
      chk("R7", "last flag", 64'(cap_l[s]), 64'(s == N - 1));
    end
    model(est, a, epos);
    chk_logs(req);
  endtask

  localparam logic [31:0] P = 32'h5a3c_e1f2;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", "idle after reset", 64'(out_valid), 64'd0);
    chk("R8", "sec reset", 64'(sec_count), 64'd0);
    chk("R8", "ded reset", 64'(ded_count), 64'd0);
    chk("R1", "code idle after reset", 64'(wr_code_valid), 64'd0);

    wr_case(32'h0000_0000);
    wr_case(32'hffff_ffff);
    wr_case(32'ha5c3_9e17);
    for (int d = 0; d < NB; d++) wr_case(32'd1 << d);

    rd_case("R2", 32'h0000_0000, 0, 0, 4'h1, 2'b00, 32'h0000_0000, 0);
    rd_case("R2", 32'hffff_ffff, 0, 0, 4'h2, 2'b00, 32'hffff_ffff, 0);
    rd_case("R2", P, 0, 0, 4'h3, 2'b00, P, 0);

    for (int d = 0; d < NB; d++)
      rd_case("R3", P, 32'd1 << d, 0, 4'(d), 2'b01, P, 16'(65 + d));

    for (int j = 0; j < 7; j++)
      rd_case("R4", P, 0, 8'd1 << j, 4'(j + 3), 2'b01, P, 16'(1 << j));
    rd_case("R4", P, 0, 8'h80, 4'hc, 2'b01, P, 16'd0);

    for (int d = 0; d < 15; d++)
      rd_case("R5", P, 32'd3 << d, 0, 4'(d), 2'b10, P ^ (32'd3 << d),
              16'((65 + d) ^ (66 + d)));
    rd_case("R5", P, 32'd1 << 3, 8'h04, 4'h9, 2'b10, P ^ 32'h8, 16'(68 ^ 4));
    rd_case("R5", P, 0, 8'h03, 4'ha, 2'b10, P, 16'd3);
    rd_case("R5", P, 32'd1 << 20, 8'h80, 4'hb, 2'b10, P ^ (32'd1 << 20), 16'(85));

    // R10: two groups back to back, the first damaged, the second clean
    cap_n = 0;
    send(P ^ 32'h0010_0000, mk_code(P), 4'h5);
    send(32'h1234_5678, mk_code(32'h1234_5678), 4'h6);
    repeat (8) @(negedge clk);
    chk("R10", "sample count", 64'(cap_n), 64'(2 * N));
    for (int s = 0; s < N; s++) begin
      chk("R10", "first group data", 64'(cap_d[s]), 64'(P[s*W +: W]));
      chk("R10", "first group status", 64'(cap_s[s]), 64'd1);
      chk("R10", "second group data", 64'(cap_d[N+s]), 64'(32'h1234_5678 >> (s*W)) & 64'hff);
      chk("R10", "second group status", 64'(cap_s[N+s]), 64'd0);
    end
    chk("R10", "second first flag", 64'(cap_f[N]), 64'd1);
    model(2'b01, 4'h5, 16'(65 + 20));
    chk_logs("R10");

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule